// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This block sits on the path of message-signalled interrupt writes. Each write arrives as an address and a data word. The unit first checks whether the write falls inside the interrupt address window. It then sorts the write into one of two kinds. A direct (compatibility) write carries its target and vector in its own bits. A remappable write carries only a handle that points into an on-chip remapping table. The unit produces one resolved interrupt with a 32-bit destination, a vector, a destination mode and a delivery mode. When the write cannot be resolved, it produces a single-cycle fault pulse and a cause code instead.

A remappable write builds its handle from bits spread across the address. When the address says so, a subhandle from the data word is added to that handle. This lets a device that can only add to its data value reach different table entries. A table write port fills the table. A control register decides whether direct writes are forwarded or dropped. The table is a synchronous-read memory. Each entry's valid flag lives in resettable flops, so every entry reads as invalid after reset.

Top module: `msi_remap_unit`

## Requirements
- R1: A write is inside the interrupt window only when address bits 31:20 equal 0xFEE and address bits 63:32 are all zero. Any other write gives a fault with cause 0 and no interrupt.
- R2: A window write with address bit 4 clear is a direct write. Its output has `out_dest` = {24'b0, address bits 19:12}, `out_vec` = data bits 7:0, `out_mode` = address bit 2, `out_dlv` = data bits 10:8 and `out_remapped` = 0.
- R3: For a direct write, `out_bcast` is 1 exactly when address bits 19:12 equal 0xFF. It is 0 for every remapped output.
- R4: While the block control is set (written through `ctrl_we`/`ctrl_block`), a direct write is dropped with a fault of cause 3. Remappable writes are not affected.
- R5: A window write with address bit 4 set is remappable. Its handle is {address bit 2, address bits 19:5}. With address bit 3 clear the data word has no effect and the handle is the table index. The output is the entry's destination, vector and mode, with `out_remapped` = 1 and `out_dlv` = 0.
- R6: With address bit 3 set, the table index is the handle plus data bits 15:0, summed at full width with no wraparound.
- R7: A remappable index greater than or equal to DEPTH gives a fault with cause 1.
- R8: A remappable index that hits an entry whose valid bit is clear gives a fault with cause 2. A table write with `cfg_valid` = 0 invalidates that entry.
- R9: A write accepted at clock edge N produces either `out_valid` or a one-cycle `fault` pulse after edge N+1, and never both for the same write.
- R10: While `out_valid` is high and `out_ready` is low, the output holds steady. Once one more write is waiting behind it, `in_ready` is low.
- R11: After reset, `out_valid` and `fault` are low, `in_ready` is high, the block control is clear and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Unit can take a write this cycle |
| in_addr | input | 62 | Write address bits 63:2 |
| in_data | input | 16 | Data word bits 15:0 (upper half has no effect) |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_dest | input | 32 | Entry destination ID |
| cfg_vec | input | 8 | Entry vector |
| cfg_mode | input | 1 | Entry destination mode |
| cfg_valid | input | 1 | Entry valid flag |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_block | input | 1 | New value of the direct-write block control |
| out_valid | output | 1 | Resolved interrupt present |
| out_ready | input | 1 | Consumer takes the interrupt |
| out_dest | output | 32 | Destination ID |
| out_vec | output | 8 | Vector |
| out_mode | output | 1 | Destination mode |
| out_dlv | output | 3 | Delivery mode |
| out_remapped | output | 1 | Result came from the table |
| out_bcast | output | 1 | Direct write to the broadcast destination |
| fault | output | 1 | One-cycle fault or drop pulse |
| fault_cause | output | 2 | 0 window, 1 range, 2 invalid entry, 3 blocked |

## Verification
Every write is accepted on a clock edge with `in_valid` and `in_ready` both high. Its result or fault appears after exactly one further edge: one edge loads the table read and the decoded request, and the next loads the output registers. The bench drives inputs on falling edges. Right after the accepting edge, it confirms that neither `out_valid` nor `fault` has appeared yet. It then samples the result at the following falling edge. In the back-pressure test, the outputs are re-sampled on several falling edges while `out_ready` is low, and the held content is compared each time.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;

  typedef enum logic [1:0] {
    K_OUTWIN = 2'd0,
    K_DIRECT = 2'd1,
    K_REMAP  = 2'd2
  } req_kind_e;

  localparam logic [1:0] FC_WINDOW  = 2'd0;
  localparam logic [1:0] FC_RANGE   = 2'd1;
  localparam logic [1:0] FC_INVALID = 2'd2;
  localparam logic [1:0] FC_BLOCKED = 2'd3;

  localparam logic [11:0] WINDOW_TAG = 12'hFEE;
  localparam int HANDLE_W = 16;
  localparam int SUM_W    = HANDLE_W + 1;

  typedef struct packed {
    logic [31:0] dest;
    logic [7:0]  vec;
    logic        mode;
  } irte_t;

endpackage

// File: rtl/msi_req_decode.sv
module msi_req_decode
  import msi_remap_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [63:2]      addr,
  input  logic [15:0]      data,
  output req_kind_e        kind,
  output logic [IDX_W-1:0] tbl_idx,
  output logic             idx_oor,
  output logic [7:0]       dir_dest,
  output logic [7:0]       dir_vec,
  output logic             dir_mode,
  output logic [2:0]       dir_dlv
);

  logic             in_window;
  logic [SUM_W-1:0] handle_ext;
  logic [SUM_W-1:0] sub_ext;
  logic [SUM_W-1:0] index_sum;

  always_comb begin
    in_window  = (addr[63:32] == 32'd0) && (addr[31:20] == WINDOW_TAG);
    handle_ext = {1'b0, addr[2], addr[19:5]};
    sub_ext    = addr[3] ? {1'b0, data} : '0;
    index_sum  = handle_ext + sub_ext;

    if (!in_window)   kind = K_OUTWIN;
    else if (addr[4]) kind = K_REMAP;
    else              kind = K_DIRECT;

    tbl_idx  = index_sum[IDX_W-1:0];
    idx_oor  = index_sum >= SUM_W'(DEPTH);
    dir_dest = addr[19:12];
    dir_vec  = data[7:0];
    dir_mode = addr[2];
    dir_dlv  = data[10:8];
  end

endmodule

// File: rtl/msi_irt.sv
module msi_irt
  import msi_remap_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  irte_t            wentry,
  input  logic             wvalid,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output irte_t            rentry,
  output logic             rvalid
);

  irte_t      mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // Payload memory: plain synchronous write/read so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wentry;
    if (re) rentry <= mem[ridx];
  end

  // Valid flags are kept in flops so reset can clear the whole table.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rvalid  <= 1'b0;
    end else begin
      if (we) valid_q[widx] <= wvalid;
      if (re) rvalid <= valid_q[ridx];
    end
  end

endmodule

// File: rtl/msi_resolve.sv
module msi_resolve
  import msi_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  req_kind_e   kind,
  input  logic        idx_oor,
  input  logic [7:0]  dir_dest,
  input  logic [7:0]  dir_vec,
  input  logic        dir_mode,
  input  logic [2:0]  dir_dlv,
  input  logic        block,
  input  irte_t       tbl_entry,
  input  logic        tbl_valid,
  input  logic        out_ready,
  output logic        pipe_ready,
  output logic        out_valid,
  output logic [31:0] out_dest,
  output logic [7:0]  out_vec,
  output logic        out_mode,
  output logic [2:0]  out_dlv,
  output logic        out_remapped,
  output logic        out_bcast,
  output logic        fault,
  output logic [1:0]  fault_cause
);

  logic      s1_v;
  req_kind_e s1_kind;
  logic      s1_oor;
  logic      s1_block;
  logic [7:0] s1_dest;
  logic [7:0] s1_vec;
  logic      s1_mode;
  logic [2:0] s1_dlv;

  logic       out_free;
  logic       s1_adv;
  logic       bad;
  logic [1:0] bad_cause;

  assign out_free   = !out_valid || out_ready;
  assign s1_adv     = s1_v && out_free;
  assign pipe_ready = !s1_v || out_free;

  always_comb begin
    bad       = 1'b0;
    bad_cause = FC_WINDOW;
    unique case (s1_kind)
      K_DIRECT: begin
        bad       = s1_block;
        bad_cause = FC_BLOCKED;
      end
      K_REMAP: begin
        if (s1_oor) begin
          bad       = 1'b1;
          bad_cause = FC_RANGE;
        end else if (!tbl_valid) begin
          bad       = 1'b1;
          bad_cause = FC_INVALID;
        end
      end
      default: begin
        bad       = 1'b1;
        bad_cause = FC_WINDOW;
      end
    endcase
  end

  // Stage 1: decoded request alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_kind  <= K_OUTWIN;
      s1_oor   <= 1'b0;
      s1_block <= 1'b0;
      s1_dest  <= '0;
      s1_vec   <= '0;
      s1_mode  <= 1'b0;
      s1_dlv   <= '0;
    end else if (pipe_ready) begin
      s1_v <= accept;
      if (accept) begin
        s1_kind  <= kind;
        s1_oor   <= idx_oor;
        s1_block <= block;
        s1_dest  <= dir_dest;
        s1_vec   <= dir_vec;
        s1_mode  <= dir_mode;
        s1_dlv   <= dir_dlv;
      end
    end
  end

  // Output registers and fault pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_dest     <= '0;
      out_vec      <= '0;
      out_mode     <= 1'b0;
      out_dlv      <= '0;
      out_remapped <= 1'b0;
      out_bcast    <= 1'b0;
      fault        <= 1'b0;
      fault_cause  <= FC_WINDOW;
    end else begin
      fault <= s1_adv && bad;
      if (s1_adv && bad) fault_cause <= bad_cause;
      if (out_free) begin
        out_valid <= s1_adv && !bad;
        if (s1_adv && !bad) begin
          if (s1_kind == K_REMAP) begin
            out_dest     <= tbl_entry.dest;
            out_vec      <= tbl_entry.vec;
            out_mode     <= tbl_entry.mode;
            out_dlv      <= 3'd0;
            out_remapped <= 1'b1;
            out_bcast    <= 1'b0;
          end else begin
            out_dest     <= {24'd0, s1_dest};
            out_vec      <= s1_vec;
            out_mode     <= s1_mode;
            out_dlv      <= s1_dlv;
            out_remapped <= 1'b0;
            out_bcast    <= (s1_dest == 8'hFF);
          end
        end
      end
    end
  end

endmodule

// File: rtl/msi_remap_unit.sv
module msi_remap_unit
  import msi_remap_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:2]      in_addr,
  input  logic [15:0]      in_data,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_dest,
  input  logic [7:0]       cfg_vec,
  input  logic             cfg_mode,
  input  logic             cfg_valid,
  input  logic             ctrl_we,
  input  logic             ctrl_block,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_dest,
  output logic [7:0]       out_vec,
  output logic             out_mode,
  output logic [2:0]       out_dlv,
  output logic             out_remapped,
  output logic             out_bcast,
  output logic             fault,
  output logic [1:0]       fault_cause
);

  req_kind_e        dec_kind;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_oor;
  logic [7:0]       dec_dest;
  logic [7:0]       dec_vec;
  logic             dec_mode;
  logic [2:0]       dec_dlv;
  logic             block_q;
  logic             accept;
  irte_t            rd_entry;
  logic             rd_valid;
  irte_t            wr_entry;

  assign accept   = in_valid && in_ready;
  assign wr_entry = '{dest: cfg_dest, vec: cfg_vec, mode: cfg_mode};

  always_ff @(posedge clk) begin
    if (rst)          block_q <= 1'b0;
    else if (ctrl_we) block_q <= ctrl_block;
  end

  msi_req_decode #(.DEPTH(DEPTH)) u_dec (
    .addr     (in_addr),
    .data     (in_data),
    .kind     (dec_kind),
    .tbl_idx  (dec_idx),
    .idx_oor  (dec_oor),
    .dir_dest (dec_dest),
    .dir_vec  (dec_vec),
    .dir_mode (dec_mode),
    .dir_dlv  (dec_dlv)
  );

  msi_irt #(.DEPTH(DEPTH)) u_irt (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .widx   (cfg_idx),
    .wentry (wr_entry),
    .wvalid (cfg_valid),
    .re     (accept),
    .ridx   (dec_idx),
    .rentry (rd_entry),
    .rvalid (rd_valid)
  );

  msi_resolve u_res (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .kind         (dec_kind),
    .idx_oor      (dec_oor),
    .dir_dest     (dec_dest),
    .dir_vec      (dec_vec),
    .dir_mode     (dec_mode),
    .dir_dlv      (dec_dlv),
    .block        (block_q),
    .tbl_entry    (rd_entry),
    .tbl_valid    (rd_valid),
    .out_ready    (out_ready),
    .pipe_ready   (in_ready),
    .out_valid    (out_valid),
    .out_dest     (out_dest),
    .out_vec      (out_vec),
    .out_mode     (out_mode),
    .out_dlv      (out_dlv),
    .out_remapped (out_remapped),
    .out_bcast    (out_bcast),
    .fault        (fault),
    .fault_cause  (fault_cause)
  );

endmodule

// File: rtl/msi_remap_chk.sv
module msi_remap_chk (
  input logic        clk,
  input logic        rst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_dest,
  input logic [7:0]  out_vec,
  input logic        out_remapped,
  input logic        out_bcast,
  input logic        fault
);

  assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !fault));

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_vec)));

  assert_bcast_direct_only_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bcast) |-> (!out_remapped && out_dest == 32'h0000_00FF));

  assert_direct_dest_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_remapped) |-> (out_dest[31:8] == 24'd0));

  assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
    !(fault && $rose(out_valid)));

endmodule

bind msi_remap_unit msi_remap_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_dest     (out_dest),
  .out_vec      (out_vec),
  .out_remapped (out_remapped),
  .out_bcast    (out_bcast),
  .fault        (fault)
);

// File: tb/sim_msi_remap_unit.sv
`timescale 1ns/1ps
module sim_msi_remap_unit;

  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] data;
    logic        flt;
    logic [1:0]  cause;
    logic [31:0] dest;
    logic [7:0]  vec;
    logic        mode;
    logic [2:0]  dlv;
    logic        remap;
    logic        bcast;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'hFEE000B0, 16'hFFFF, 1'b0, 2'd0, 32'h0001_2345, 8'h41, 1'b0, 3'd0, 1'b1, 1'b0}, // R5 idx5, data ignored
    '{32'hFEE004B0, 16'h0000, 1'b0, 2'd0, 32'h0000_0300, 8'h77, 1'b1, 3'd0, 1'b1, 1'b0}, // R5 idx37
    '{32'hFEE003D8, 16'h0007, 1'b0, 2'd0, 32'h0000_0300, 8'h77, 1'b1, 3'd0, 1'b1, 1'b0}, // R6 30+7
    '{32'hFEE00798, 16'h0003, 1'b0, 2'd0, 32'hABCD_0001, 8'h99, 1'b0, 3'd0, 1'b1, 1'b0}, // R6 60+3 last entry
    '{32'hFEE00798, 16'h0004, 1'b1, 2'd1, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R7 60+4
    '{32'hFEE000B4, 16'h0000, 1'b1, 2'd1, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R7 handle top bit
    '{32'hFEEFFFFC, 16'h0001, 1'b1, 2'd1, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R6 no wrap
    '{32'hFEE00150, 16'h0000, 1'b1, 2'd2, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R8 written invalid
    '{32'hFEE00010, 16'h0000, 1'b1, 2'd2, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R8 never written
    '{32'hFED000B0, 16'h0000, 1'b1, 2'd0, 32'h0,         8'h00, 1'b0, 3'd0, 1'b0, 1'b0}, // R1 outside window
    '{32'hFEE12004, 16'h0531, 1'b0, 2'd0, 32'h0000_0012, 8'h31, 1'b1, 3'd5, 1'b0, 1'b0}, // R2 direct
    '{32'hFEEFF000, 16'h00A0, 1'b0, 2'd0, 32'h0000_00FF, 8'hA0, 1'b0, 3'd0, 1'b0, 1'b1}  // R3 broadcast
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [63:2]      in_addr = '0;
  logic [15:0]      in_data = '0;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0]      cfg_dest = '0;
  logic [7:0]       cfg_vec = '0;
  logic             cfg_mode = 1'b0;
  logic             cfg_valid = 1'b0;
  logic             ctrl_we = 1'b0;
  logic             ctrl_block = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [31:0]      out_dest;
  logic [7:0]       out_vec;
  logic             out_mode;
  logic [2:0]       out_dlv;
  logic             out_remapped;
  logic             out_bcast;
  logic             fault;
  logic [1:0]       fault_cause;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  msi_remap_unit #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_dest(cfg_dest), .cfg_vec(cfg_vec), .cfg_mode(cfg_mode), .cfg_valid(cfg_valid),
    .ctrl_we(ctrl_we), .ctrl_block(ctrl_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_dest(out_dest), .out_vec(out_vec), .out_mode(out_mode), .out_dlv(out_dlv),
    .out_remapped(out_remapped), .out_bcast(out_bcast), .fault(fault), .fault_cause(fault_cause)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic cfg_write(input int idx, input logic [31:0] d, input logic [7:0] v,
                           input logic m, input logic ok);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_dest = d; cfg_vec = v; cfg_mode = m; cfg_valid = ok;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_block(input logic b);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_block = b;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // Drive one write; returns at the falling edge right after the accepting edge.
  task automatic send(input logic [63:0] a, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a[63:2]; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Full check of one write against expected fields, including latency (R9).
  task automatic run_one(input string req, input logic [63:0] a, input logic [15:0] d,
                         input vec_t e);
    send(a, d);
    chk({req, " R9 early"}, {62'd0, out_valid, fault}, 64'd0);
    @(negedge clk);
    chk({req, " R9 outcome"}, {62'd0, out_valid, fault}, {62'd0, !e.flt, e.flt});
    if (e.flt) begin
      chk({req, " cause"}, 64'(fault_cause), 64'(e.cause));
    end else begin
      chk({req, " dest"}, 64'(out_dest), 64'(e.dest));
      chk({req, " vec/mode/dlv"}, {52'd0, out_vec, out_mode, out_dlv},
          {52'd0, e.vec, e.mode, e.dlv});
      chk({req, " remap/bcast"}, {62'd0, out_remapped, out_bcast}, {62'd0, e.remap, e.bcast});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    vec_t e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid/fault", {62'd0, out_valid, fault}, 64'd0);
    chk("R11 in_ready", 64'(in_ready), 64'd1);
    e = '{32'h0, 16'h0, 1'b1, 2'd2, 32'h0, 8'h0, 1'b0, 3'd0, 1'b0, 1'b0};
    run_one("R11 table invalid", {32'd0, 32'hFEE000B0}, 16'h0, e);
    e = '{32'h0, 16'h0, 1'b0, 2'd0, 32'h12, 8'h31, 1'b1, 3'd5, 1'b0, 1'b0};
    run_one("R11 block clear", {32'd0, 32'hFEE12004}, 16'h0531, e);

    cfg_write(5,  32'h0001_2345, 8'h41, 1'b0, 1'b1);
    cfg_write(37, 32'h0000_0300, 8'h77, 1'b1, 1'b1);
    cfg_write(63, 32'hABCD_0001, 8'h99, 1'b0, 1'b1);
    cfg_write(10, 32'h5555_5555, 8'h55, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      run_one($sformatf("vec%0d R1-R8", i), {32'd0, TBL[i].addr}, TBL[i].data, TBL[i]);
    end

    // R1 upper address bits set
    e = '{32'h0, 16'h0, 1'b1, 2'd0, 32'h0, 8'h0, 1'b0, 3'd0, 1'b0, 1'b0};
    run_one("R1 upper bits", {32'h0000_0001, 32'hFEE000B0}, 16'h0, e);

    // R4 block control
    set_block(1'b1);
    e = '{32'h0, 16'h0, 1'b1, 2'd3, 32'h0, 8'h0, 1'b0, 3'd0, 1'b0, 1'b0};
    run_one("R4 direct blocked", {32'd0, 32'hFEE12004}, 16'h0531, e);
    run_one("R4 remap unaffected", {32'd0, TBL[1].addr}, TBL[1].data, TBL[1]);
    set_block(1'b0);
    run_one("R4 unblocked", {32'd0, TBL[10].addr}, TBL[10].data, TBL[10]);

    // R8 invalidate an entry that was valid
    cfg_write(5, 32'h0001_2345, 8'h41, 1'b0, 1'b0);
    e = '{32'h0, 16'h0, 1'b1, 2'd2, 32'h0, 8'h0, 1'b0, 3'd0, 1'b0, 1'b0};
    run_one("R8 invalidated", {32'd0, TBL[0].addr}, TBL[0].data, e);

    // R10 back-pressure
    out_ready = 1'b0;
    send({32'd0, TBL[1].addr}, 16'h0);         // A: entry 37
    @(negedge clk);
    chk("R10 A loaded", {32'd0, out_dest}, 64'h300);
    send({32'd0, TBL[3].addr}, TBL[3].data);   // B: entry 63
    chk("R10 in_ready low", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 hold", {23'd0, out_valid, out_vec, out_dest}, {23'd0, 1'b1, 8'h77, 32'h300});
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 B after release", {23'd0, out_valid, out_vec, out_dest},
        {23'd0, 1'b1, 8'h99, 32'hABCD_0001});
    @(negedge clk);
    chk("R10 drained", {63'd0, out_valid}, 64'd0);

    summary();
    $finish;
  end

endmodule